// File: doc/BRIEF.md
# Printhead Strobe Guard

This block holds the processor's printhead control word and turns it into gated drive outputs. The word has four section strobes, a head load line and a head supply enable. Software writes the word over a one-cycle write strobe and can read back the stored word together with a trip flag.

A protection timer stops a stuck strobe from overheating the head. The timer counts slow tick pulses, but only while at least one stored strobe is set. When the count reaches a fixed limit, the block drives every strobe output and the supply enable low. They stay low until software clears all four stored strobes, which clears the count and the trip flag. A power-fail input works without waiting for a clock: while it is asserted, the strobe outputs and the supply enable are held low, whatever the stored word or the timer holds. The tick is a single-cycle enable pulse in the system clock domain. Reset is synchronous.

Top module: `phead_guard`

## Requirements
- R1: A cycle with `wr_en` high stores `wr_data` into the control word, and `rd_data` shows it from the next cycle. The fields are: bits 3..0 are the strobes, bit 4 is load, bit 5 is supply enable, and `rd_data` bit 6 is the trip flag.
- R2: With no trip and power-fail low, `strobe_o`, `load_o` and `supply_en_o` equal the stored fields, starting the cycle after the write.
- R3: The timer advances only on a cycle where `tick` is high and at least one stored strobe is set. Ticks seen while all strobes are clear are not counted.
- R4: In the cycle after the sixth counted tick, `tripped_o` goes high and both `strobe_o` and `supply_en_o` go to zero. `load_o` is not affected.
- R5: Once tripped, the block stays tripped for any number of further ticks while any stored strobe remains set. The counter cannot wrap.
- R6: One cycle after all four stored strobes read zero, the trip flag and the count are cleared. A new trip then needs six more counted ticks.
- R7: Clearing only some of the strobes while at least one stays set neither clears the trip nor resets the count.
- R8: While `pwr_fail` is high, `strobe_o` and `supply_en_o` are zero in that same cycle. The stored word, the timer and `load_o` are unchanged by it.
- R9: Synchronous reset clears the word, the count and the trip flag, so every output reads zero.
- R10: `rd_data` keeps showing the stored word while the outputs are suppressed by a trip or by power-fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 6 | Control word to store |
| tick | input | 1 | Slow timebase enable pulse |
| pwr_fail | input | 1 | Power-fail force-off, active high |
| rd_data | output | 7 | Stored word with trip flag in the top bit |
| strobe_o | output | 4 | Gated section strobes |
| load_o | output | 1 | Head load line |
| supply_en_o | output | 1 | Gated head supply enable |
| tripped_o | output | 1 | Protection timer has tripped |

## Verification
Ticks are applied in several patterns, and each pattern separates different faults.
- Ticks with no strobe set, followed by a strobe, show whether idle ticks are wrongly counted.
- A single strobe held through exactly six ticks, with a check after five, detects an off-by-one in the trip limit.
- A long run of ticks after the trip would expose a counter that wraps and releases.
- Partial and full strobe releases tell apart "any strobe" from "all strobes" as the re-arm condition.
- Power-fail pulses given before and during a trip show that the force-off acts in the same cycle and leaves the stored word and the timer as they were.

// File: rtl/phead_guard_pkg.sv
package phead_guard_pkg;
   localparam int unsigned NUM_STRB = 4;
   localparam int unsigned CTRL_W   = NUM_STRB + 2;

   typedef struct packed {
      logic                supply;
      logic                load;
      logic [NUM_STRB-1:0] strb;
   } ctrl_word_t;
endpackage

// File: rtl/phead_ctrl_latch.sv
module phead_ctrl_latch
   import phead_guard_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       wr_en,
   input  ctrl_word_t wr_word,
   output ctrl_word_t word_q
);
   always_ff @(posedge clk) begin
      if (rst)        word_q <= '0;
      else if (wr_en) word_q <= wr_word;
   end
endmodule

// File: rtl/phead_wdog.sv
module phead_wdog #(
   parameter int unsigned LIMIT = 6,
   parameter int unsigned CNT_W = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic active,
   input  logic tick,
   output logic trip_q
);
   localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);
   localparam logic [CNT_W-1:0] ONE_V   = CNT_W'(1);

   initial begin
      if (LIMIT < 1) $error("phead_wdog: LIMIT must be at least 1");
      if (LIMIT >= (1 << CNT_W)) $error("phead_wdog: LIMIT does not fit CNT_W");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nx;

   assign cnt_nx = cnt_q + ONE_V;

   always_ff @(posedge clk) begin
      if (rst || !active) begin
         cnt_q  <= '0;
         trip_q <= 1'b0;
      end else if (tick && !trip_q) begin
         cnt_q <= cnt_nx;
         if (cnt_nx == LIMIT_V) trip_q <= 1'b1;
      end
   end
endmodule

// File: rtl/phead_out_gate.sv
module phead_out_gate #(
   parameter int unsigned N         = 4,
   parameter bit          PF_ACT_HI = 1'b1
) (
   input  logic [N-1:0] strb_in,
   input  logic         supply_in,
   input  logic         trip,
   input  logic         pf_raw,
   output logic [N-1:0] strb_out,
   output logic         supply_out
);
   logic pf_on;
   logic kill;

   generate
      if (PF_ACT_HI) begin : g_pf_hi
         assign pf_on = pf_raw;
      end else begin : g_pf_lo
         assign pf_on = ~pf_raw;
      end
   endgenerate

   assign kill = trip | pf_on;

   for (genvar i = 0; i < N; i++) begin : g_strb
      assign strb_out[i] = strb_in[i] & ~kill;
   end

   assign supply_out = supply_in & ~kill;
endmodule

// File: rtl/phead_guard.sv
module phead_guard
   import phead_guard_pkg::*;
#(
   parameter int unsigned TRIP_TICKS = 6,
   parameter int unsigned TCNT_W     = 4,
   parameter bit          PF_ACT_HI  = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                wr_en,
   input  logic [CTRL_W-1:0]   wr_data,
   input  logic                tick,
   input  logic                pwr_fail,
   output logic [CTRL_W:0]     rd_data,
   output logic [NUM_STRB-1:0] strobe_o,
   output logic                load_o,
   output logic                supply_en_o,
   output logic                tripped_o
);
   initial begin
      if (NUM_STRB < 1) $error("phead_guard: need at least one strobe");
   end

   ctrl_word_t word_q;
   logic       trip;

   phead_ctrl_latch u_latch (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_word (ctrl_word_t'(wr_data)),
      .word_q  (word_q)
   );

   phead_wdog #(.LIMIT(TRIP_TICKS), .CNT_W(TCNT_W)) u_wdog (
      .clk    (clk),
      .rst    (rst),
      .active (|word_q.strb),
      .tick   (tick),
      .trip_q (trip)
   );

   phead_out_gate #(.N(NUM_STRB), .PF_ACT_HI(PF_ACT_HI)) u_gate (
      .strb_in    (word_q.strb),
      .supply_in  (word_q.supply),
      .trip       (trip),
      .pf_raw     (pwr_fail),
      .strb_out   (strobe_o),
      .supply_out (supply_en_o)
   );

   assign load_o    = word_q.load;
   assign tripped_o = trip;
   assign rd_data   = {trip, word_q};
endmodule

// File: rtl/phead_guard_chk.sv
module phead_guard_chk
   import phead_guard_pkg::*;
(
   input logic                clk,
   input logic                rst,
   input logic                wr_en,
   input logic [CTRL_W-1:0]   wr_data,
   input logic                pwr_fail,
   input logic [CTRL_W:0]     rd_data,
   input logic [NUM_STRB-1:0] strobe_o,
   input logic                load_o,
   input logic                supply_en_o,
   input logic                tripped_o
);
   p_write_lands_r1: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> rd_data[CTRL_W-1:0] == $past(wr_data));

   p_trip_kills_r4: assert property (@(posedge clk) disable iff (rst)
      tripped_o |-> (strobe_o == '0) && !supply_en_o);

   p_trip_holds_r5: assert property (@(posedge clk) disable iff (rst)
      (tripped_o && (rd_data[NUM_STRB-1:0] != '0) && !wr_en) |=> tripped_o);

   p_release_clears_r6: assert property (@(posedge clk) disable iff (rst)
      (rd_data[NUM_STRB-1:0] == '0) |=> !tripped_o);

   p_pfail_kills_r8: assert property (@(posedge clk) disable iff (rst)
      pwr_fail |-> (strobe_o == '0) && !supply_en_o);

   p_load_passes_r8: assert property (@(posedge clk) disable iff (rst)
      load_o == rd_data[NUM_STRB]);

   p_reset_clears_r9: assert property (@(posedge clk)
      $past(rst) |-> (rd_data == '0) && (strobe_o == '0) && !load_o && !supply_en_o && !tripped_o);
endmodule

bind phead_guard phead_guard_chk u_chk (
   .clk         (clk),
   .rst         (rst),
   .wr_en       (wr_en),
   .wr_data     (wr_data),
   .pwr_fail    (pwr_fail),
   .rd_data     (rd_data),
   .strobe_o    (strobe_o),
   .load_o      (load_o),
   .supply_en_o (supply_en_o),
   .tripped_o   (tripped_o)
);

// File: tb/phead_guard_bench.sv
`timescale 1ns/1ps
module phead_guard_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0;
   logic [5:0] wr_data = '0;
   logic       tick = 1'b0;
   logic       pwr_fail = 1'b0;
   logic [6:0] rd_data;
   logic [3:0] strobe_o;
   logic       load_o;
   logic       supply_en_o;
   logic       tripped_o;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   // behavioural reference state
   int m_strb = 0, m_load = 0, m_sup = 0, m_cnt = 0, m_trip = 0;

   always #2.5 clk = ~clk;

   phead_guard u_phead_guard (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .tick(tick),
      .pwr_fail(pwr_fail), .rd_data(rd_data), .strobe_o(strobe_o), .load_o(load_o),
      .supply_en_o(supply_en_o), .tripped_o(tripped_o)
   );

   always @(posedge clk) begin
      if (rst) begin
         m_strb = 0; m_load = 0; m_sup = 0; m_cnt = 0; m_trip = 0;
      end else begin
         if (m_strb == 0) begin
            m_cnt = 0; m_trip = 0;
         end else if (tick && m_trip == 0) begin
            m_cnt = m_cnt + 1;
            if (m_cnt == 6) m_trip = 1;
         end
         if (wr_en) begin
            m_strb = wr_data % 16;
            m_load = (wr_data / 16) % 2;
            m_sup  = (wr_data / 32) % 2;
         end
      end
   end

   task automatic chk(string tag, string what, int act, int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare(string tag);
      bit kill;
      kill = (m_trip != 0) || pwr_fail;
      chk(tag, "strobe_o", strobe_o, kill ? 0 : m_strb);
      chk(tag, "supply_en_o", supply_en_o, kill ? 0 : m_sup);
      chk(tag, "load_o", load_o, m_load);
      chk(tag, "tripped_o", tripped_o, m_trip);
      chk(tag, "rd_data", rd_data, m_trip * 64 + m_sup * 32 + m_load * 16 + m_strb);
   endtask

   // drive one cycle of inputs at the falling edge, compare, then let the rising edge occur
   task automatic step(string tag, bit w, int d, bit t, bit pf);
      @(negedge clk);
      wr_en = w; wr_data = 6'(d); tick = t; pwr_fail = pf;
      #0.5;
      compare(tag);
   endtask

   task automatic ticks(string tag, int n, bit pf);
      for (int i = 0; i < n; i++) begin
         step(tag, 0, 0, 1, pf);
         step(tag, 0, 0, 0, pf);
      end
   endtask

   initial begin
      #200000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      step("R9", 0, 0, 0, 0);
      rst = 1'b0;
      step("R9", 0, 0, 0, 0);
      // R1 / R2: plain writes pass through
      step("R1", 1, 6'h35, 0, 0);
      step("R2", 0, 0, 0, 0);
      step("R1", 1, 6'h1A, 0, 0);
      step("R2", 0, 0, 0, 0);
      // R3: ticks with no strobe set are ignored
      step("R3", 1, 6'h30, 0, 0);
      ticks("R3", 8, 0);
      step("R3", 1, 6'h21, 0, 0);
      ticks("R3", 5, 0);
      chk("R3", "tripped_o after 5 counted", tripped_o, 0);
      // R4: sixth counted tick trips
      ticks("R4", 1, 0);
      chk("R4", "tripped_o after 6 counted", tripped_o, 1);
      // R5 / R10: saturates, word still readable
      ticks("R5", 20, 0);
      step("R10", 0, 0, 0, 0);
      // R7: partial release keeps trip
      step("R7", 1, 6'h33, 0, 0);
      step("R7", 1, 6'h31, 0, 0);
      ticks("R7", 2, 0);
      // R6: full release clears, re-arm needs six more
      step("R6", 1, 6'h30, 0, 0);
      step("R6", 0, 0, 0, 0);
      step("R6", 1, 6'h3C, 0, 0);
      ticks("R6", 5, 0);
      // R7: partial release before trip keeps count
      step("R7", 1, 6'h34, 0, 0);
      ticks("R7", 1, 0);
      chk("R7", "tripped_o keep count", tripped_o, 1);
      step("R6", 1, 6'h00, 0, 0);
      step("R6", 0, 0, 0, 0);
      // R8: power-fail kills same cycle, state preserved
      step("R8", 1, 6'h3F, 0, 0);
      step("R8", 0, 0, 0, 1);
      step("R8", 0, 0, 1, 1);
      step("R8", 0, 0, 0, 0);
      ticks("R8", 4, 1);
      ticks("R8", 1, 0);
      step("R8", 0, 0, 0, 1);
      step("R10", 0, 0, 0, 0);
      // R9: reset mid-trip
      @(negedge clk); rst = 1'b1;
      step("R9", 0, 0, 0, 0);
      rst = 1'b0;
      step("R9", 0, 0, 0, 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule